// File: doc/BRIEF.md
# Indexed Color Palette Access Port

This block holds a 256-entry color lookup table. Each entry has three 8-bit color components. Software reaches the table through a small register port with an address, data and strobe interface. To load colors, software first programs a write index. It then writes the components one byte at a time to a shared data register. The entry is committed to the table only when its last component arrives. To inspect colors, software programs a read index and reads the same data register three times per entry. Both indexes advance by themselves after a complete entry, and both wrap from 255 to 0.

Programming the read index cancels any write sequence that is still in progress, and the bytes already supplied for that entry are discarded. A status register shows whether the read or the write sequence was started most recently. The display pipeline has its own combinational lookup port. It turns a pixel index into a 24-bit color and never changes the register-side sequence state. Register access to the table works the same in every display mode.

Top module: `clut_port`

## Requirements
- R1: After reset, the read index is 0x00, both byte counters are 0, and the status register (address 3) reads 0x00.
- R2: Three writes to the data register (address 2) supply red, then green, then blue. On the third write the entry at the write index becomes {red,green,blue}, with red in bits 23:16 and blue in bits 7:0. The new value shows on `pix_rgb` from the next cycle.
- R3: After each committed entry the write index increments by one, wrapping from 255 to 0. Reading address 1 returns the current write index.
- R4: Reads of the data register return red, green and blue of the entry at the read index, in that order. After the third read the read index increments by one, wrapping from 255 to 0.
- R5: Writing the read index (address 0) discards a partly written entry. The table is not changed, the write index is kept, and the next data write is taken as red.
- R6: Writing the write index (address 1) sets the index and restarts the write byte counter, so the next data write is taken as red.
- R7: Status bit 0 reads 1 after the read index was written more recently than the write index, and 0 otherwise. The other status bits read 0.
- R8: `pix_rgb` shows the entry selected by `pix_idx` in the same cycle. Changing `pix_idx` has no effect on the read or write sequence.
- R9: The read-index register is write-only, and a read of address 0 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 read index, 1 write index, 2 data, 3 status |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the strobe cycle |
| pix_idx | input | 8 | Pixel index from the display pipeline |
| pix_rgb | output | 24 | Color of the selected entry, {red,green,blue} |

## Verification
Register read data is combinational. It is due in the same cycle as the read strobe and reflects every write that was strobed in earlier cycles. The scoreboard monitor therefore samples `reg_rdata` on the falling edge of the cycle in which `reg_rd` is high. A committed entry and any index or status change become visible one clock edge after the write strobe. The driver always separates accesses by at least one edge, so each expected value is pushed only once the state it depends on is settled. The pixel port is combinational as well, and it is checked on the falling edge after `pix_idx` is set.

// File: rtl/clut_pkg.sv
package clut_pkg;
  parameter int unsigned IDX_W_DEF  = 8;
  parameter int unsigned COMP_W_DEF = 8;
  parameter int unsigned NCOMP      = 3;
  parameter int unsigned CNT_W      = 2;

  typedef enum logic [1:0] {
    A_RIDX = 2'd0,
    A_WIDX = 2'd1,
    A_DATA = 2'd2,
    A_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned COMP_W = COMP_W_DEF,
  localparam int unsigned ENT_W = NCOMP * COMP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ridx,
  input  logic                 wr_widx,
  input  logic                 wr_data,
  input  logic                 rd_data,
  input  logic [COMP_W-1:0]    wdata,
  output logic [IDX_W-1:0]     rd_idx,
  output logic [CNT_W-1:0]     rd_cnt,
  output logic [IDX_W-1:0]     wr_idx,
  output logic                 seq_rd,
  output logic                 commit,
  output logic [ENT_W-1:0]     commit_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCOMP - 1);

  logic [IDX_W-1:0]  ridx_q, ridx_d, widx_q, widx_d;
  logic [CNT_W-1:0]  rcnt_q, rcnt_d, wcnt_q, wcnt_d;
  logic              seq_q, seq_d;
  logic              ridx_en, widx_en, rcnt_en, wcnt_en, seq_en;
  logic              rd_last, wr_take;
  logic [COMP_W-1:0] stg_q [NCOMP-1];

  assign rd_last = rd_data && (rcnt_q == LAST) && !wr_ridx;
  assign wr_take = wr_data && !wr_ridx && !wr_widx;
  assign commit  = wr_take && (wcnt_q == LAST);

  // read side next state
  always_comb begin
    ridx_d  = ridx_q;
    rcnt_d  = rcnt_q;
    ridx_en = 1'b0;
    rcnt_en = 1'b0;
    if (wr_ridx) begin
      ridx_d  = wdata[IDX_W-1:0];
      rcnt_d  = '0;
      ridx_en = 1'b1;
      rcnt_en = 1'b1;
    end else if (rd_data) begin
      rcnt_en = 1'b1;
      if (rcnt_q == LAST) begin
        rcnt_d  = '0;
        ridx_d  = ridx_q + 1'b1;
        ridx_en = 1'b1;
      end else begin
        rcnt_d = rcnt_q + 1'b1;
      end
    end
  end

  // write side next state
  always_comb begin
    widx_d  = widx_q;
    wcnt_d  = wcnt_q;
    widx_en = 1'b0;
    wcnt_en = 1'b0;
    if (wr_widx) begin
      widx_d  = wdata[IDX_W-1:0];
      wcnt_d  = '0;
      widx_en = 1'b1;
      wcnt_en = 1'b1;
    end else if (wr_ridx) begin
      wcnt_d  = '0;
      wcnt_en = 1'b1;
    end else if (wr_take) begin
      wcnt_en = 1'b1;
      if (wcnt_q == LAST) begin
        wcnt_d  = '0;
        widx_d  = widx_q + 1'b1;
        widx_en = 1'b1;
      end else begin
        wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    seq_en = wr_ridx || wr_widx;
    seq_d  = wr_ridx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q <= '0;
      widx_q <= '0;
      rcnt_q <= '0;
      wcnt_q <= '0;
      seq_q  <= 1'b0;
    end else begin
      if (ridx_en) ridx_q <= ridx_d;
      if (widx_en) widx_q <= widx_d;
      if (rcnt_en) rcnt_q <= rcnt_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
      if (seq_en)  seq_q  <= seq_d;
    end
  end

  // staging registers for the leading components
  for (genvar k = 0; k < NCOMP - 1; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '0;
      else if (wr_take && (wcnt_q == CNT_W'(k))) stg_q[k] <= wdata;
    end
    assign commit_data[(NCOMP-1-k)*COMP_W +: COMP_W] = stg_q[k];
  end
  assign commit_data[COMP_W-1:0] = wdata;

  assign rd_idx = ridx_q;
  assign rd_cnt = rcnt_q;
  assign wr_idx = widx_q;
  assign seq_rd = seq_q;

  AST_WIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> widx_q == $past(widx_q) + 1'b1); // R3
  AST_RIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> ridx_q == $past(ridx_q) + 1'b1); // R4
  AST_ABORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ridx |=> (wcnt_q == '0) && $stable(widx_q)); // R5
  AST_WIDX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_widx |=> wcnt_q == '0); // R6
  AST_STATUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ridx |=> seq_q); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt_q <= LAST) && (wcnt_q <= LAST)); // R1
endmodule

// File: rtl/clut_mem.sv
module clut_mem
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned COMP_W = COMP_W_DEF,
  localparam int unsigned ENT_W   = NCOMP * COMP_W,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [ENT_W-1:0] rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [ENT_W-1:0] rdata_b
);
  logic [ENT_W-1:0] tbl [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (waddr == IDX_W'(e))) tbl[e] <= wdata;
    end
  end

  assign rdata_a = tbl[raddr_a];
  assign rdata_b = tbl[raddr_b];

  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tbl[$past(waddr)] == $past(wdata)); // R2
endmodule

// File: rtl/clut_port.sv
module clut_port
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned COMP_W = COMP_W_DEF,
  localparam int unsigned ENT_W = NCOMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [COMP_W-1:0] reg_wdata,
  output logic [COMP_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [ENT_W-1:0]  pix_rgb
);
  logic              wr_ridx, wr_widx, wr_data, rd_data;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [CNT_W-1:0]  rd_cnt;
  logic              seq_rd, commit;
  logic [ENT_W-1:0]  commit_data, reg_ent;
  logic [COMP_W-1:0] comp_sel;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_ridx = reg_wr && (sel == A_RIDX);
  assign wr_widx = reg_wr && (sel == A_WIDX);
  assign wr_data = reg_wr && (sel == A_DATA);
  assign rd_data = reg_rd && (sel == A_DATA);

  clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_ridx(wr_ridx), .wr_widx(wr_widx), .wr_data(wr_data), .rd_data(rd_data),
    .wdata(reg_wdata),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt), .wr_idx(wr_idx), .seq_rd(seq_rd),
    .commit(commit), .commit_data(commit_data)
  );

  clut_mem #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(commit), .waddr(wr_idx), .wdata(commit_data),
    .raddr_a(rd_idx), .rdata_a(reg_ent),
    .raddr_b(pix_idx), .rdata_b(pix_rgb)
  );

  // component of the read entry picked by the byte counter, red first
  always_comb begin
    comp_sel = '0;
    for (int k = 0; k < NCOMP; k++) begin
      if (rd_cnt == CNT_W'(k)) comp_sel = reg_ent[(NCOMP-1-k)*COMP_W +: COMP_W];
    end
  end

  always_comb begin
    unique case (sel)
      A_RIDX:  reg_rdata = '0;
      A_WIDX:  reg_rdata = COMP_W'(wr_idx);
      A_DATA:  reg_rdata = comp_sel;
      A_STAT:  reg_rdata = COMP_W'(seq_rd);
      default: reg_rdata = '0;
    endcase
  end

  AST_RIDX_WO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == A_RIDX) |-> reg_rdata == '0); // R9
  AST_PIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reg_rd) |=> $stable(rd_idx) && $stable(wr_idx)); // R8
endmodule

// File: tb/tb_clut_port.sv
module tb_clut_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb [$];

  always #4 clk = ~clk;

  clut_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  // monitor: read data is due in the strobe cycle
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty act=%h exp=none", reg_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (reg_rdata !== e.val) begin
          failures++;
          $display("FAIL %s act=%h exp=%h", e.tag, reg_rdata, e.val);
        end
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic pix_check(input logic [7:0] i, input logic [23:0] exp, input string tag);
    @(posedge clk); #1;
    pix_idx = i;
    @(negedge clk);
    checks++;
    if (pix_rgb !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, pix_rgb, exp);
    end
  endtask

  task automatic put_entry(input logic [23:0] c);
    reg_write(2'd2, c[23:16]);
    reg_write(2'd2, c[15:8]);
    reg_write(2'd2, c[7:0]);
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 / R9 reset state
    reg_read(2'd3, 8'h00, "R1 status after reset");
    reg_read(2'd1, 8'h00, "R1 write index after reset");
    reg_read(2'd0, 8'h00, "R9 read index is write-only");

    // R2 / R3 commit and increment
    reg_write(2'd1, 8'd5);
    put_entry(24'h112233);
    pix_check(8'd5, 24'h112233, "R2 entry 5 committed");
    reg_read(2'd1, 8'd6, "R3 write index increments");
    put_entry(24'h445566);
    reg_write(2'd1, 8'd255);
    put_entry(24'hAABBCC);
    reg_read(2'd1, 8'd0, "R3 write index wraps");
    put_entry(24'h0D0E0F);
    pix_check(8'd0, 24'h0D0E0F, "R3 commit after wrap");
    reg_read(2'd3, 8'h00, "R7 status after write-index write");

    // R4 read order and auto increment
    reg_write(2'd0, 8'd5);
    reg_read(2'd3, 8'h01, "R7 status after read-index write");
    reg_read(2'd2, 8'h11, "R4 red");
    reg_read(2'd2, 8'h22, "R4 green");
    reg_read(2'd2, 8'h33, "R4 blue");
    reg_read(2'd2, 8'h44, "R4 next entry red");
    reg_write(2'd0, 8'd255);
    reg_read(2'd2, 8'hAA, "R4 entry 255 red");
    reg_read(2'd2, 8'hBB, "R4 entry 255 green");
    reg_read(2'd2, 8'hCC, "R4 entry 255 blue");
    reg_read(2'd2, 8'h0D, "R4 read index wraps");
    reg_read(2'd0, 8'h00, "R9 read index still reads zero");

    // R5 abort of a partial write
    reg_write(2'd1, 8'd10);
    put_entry(24'h010101);
    reg_write(2'd1, 8'd10);
    reg_write(2'd2, 8'h99);
    reg_write(2'd2, 8'h98);
    reg_write(2'd0, 8'd5);
    pix_check(8'd10, 24'h010101, "R5 table unchanged by abort");
    reg_read(2'd1, 8'd10, "R5 write index kept");
    put_entry(24'h414243);
    pix_check(8'd10, 24'h414243, "R5 fresh sequence after abort");

    // R6 write index restarts counter
    reg_write(2'd1, 8'd20);
    reg_write(2'd2, 8'h77);
    reg_write(2'd1, 8'd20);
    put_entry(24'h010203);
    pix_check(8'd20, 24'h010203, "R6 restart at red");
    reg_read(2'd3, 8'h00, "R7 status back to write");

    // R8 pixel port leaves sequences alone
    reg_write(2'd0, 8'd5);
    reg_read(2'd2, 8'h11, "R8 first byte");
    pix_check(8'd6, 24'h445566, "R8 pixel lookup entry 6");
    pix_check(8'd255, 24'hAABBCC, "R8 pixel lookup entry 255");
    reg_read(2'd2, 8'h22, "R8 sequence undisturbed");
    reg_read(2'd1, 8'd21, "R8 write index undisturbed");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard left act=%0d exp=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule